// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Shadowed Update and Run-Count Stop

The block drives one pulse-width modulated output from a small word-addressed register port. Software programs a period length and an active length, both counted in ticks, and a control word. The control word selects the run mode, the alignment, the output level for each phase, the tick source and the run count. A tick is either every clock cycle or one pulse from a programmable divider. In free-running mode the waveform repeats until software clears the enable bit. In counted-run mode the channel emits a set number of periods. It then clears its own enable bit and sets a sticky completion flag. That flag can drive an interrupt line.

Software sees three values: period, active length and the two level bits. Each of them has a programmed copy and a working copy. The working copy is refreshed from the programmed copy while the channel is stopped and at every period boundary. A hold bit in the control word suspends that refresh. Software can set the hold bit, rewrite all three values and then clear the hold bit. The whole new set then takes effect at one period boundary, and no period ever mixes old and new settings.

The sequencer has three states. It sits in `ST_IDLE` while stopped. It moves to `ST_UP` when the enable bit is set and the mode field selects a waveform mode. In `ST_UP` the count rises. On reaching the top the sequencer either wraps to 0 and stays in `ST_UP` (edge-aligned), or moves to `ST_DOWN` (center-aligned). `ST_DOWN` returns to `ST_UP` when the count falls to 0. Any running state goes back to `ST_IDLE` when the enable bit is cleared or when a counted run ends.

Top module: `pwm_chan`

## Requirements
- R1: After reset, the output and the interrupt line are low. The control word reads 0 and the count register (byte offset 0x00) reads 0.
- R2: While the enable bit (control bit 0) is 0, the output holds the idle level from control bit 4 (1 = high, 0 = low) and the count reads 0.
- R3: In edge-aligned mode (control bit 5 = 0) with free-running selected (control bits [2:1] = 01), one period lasts P ticks. The output takes the active level from control bit 3 for the first D ticks of each period, and the idle level for the rest. P is the period register (offset 0x04) and D is the active-length register (offset 0x08).
- R4: In center-aligned mode (control bit 5 = 1) the count rises from 0 to P-1 and falls back to 0. Each end value lasts two ticks, so one period is 2P ticks, and the output is active for 2D of them (D < P).
- R5: With control bit 9 = 1, one tick is issued every 2N clock cycles, where N is control bits [23:16]; N = 0 means every 512 cycles. With bit 9 = 0, every cycle is a tick. Control bits [13:12] are stored and read back unchanged.
- R6: While the hold bit (control bit 6) is 1, new values written to period, active length and the two level bits do not change the waveform.
- R7: After the hold bit is cleared, the new period, active length and levels take effect together from the next period boundary.
- R8: In counted-run mode (control bits [2:1] = 00), the channel emits K+1 periods, where K is control bits [31:24], so a run lasts 1 to 256 periods. It then clears control bit 0 by itself and returns the output to the idle level.
- R9: When a counted run ends, status bit 0 at offset 0x10 is set. Writing 1 to that bit clears it. The interrupt line equals the status bit gated by enable bit 0 at offset 0x14.
- R10: The mode field values 10 and 11 do not start the channel: the output stays at the idle level and the count stays at 0.
- R11: While running, the count register reads the current tick count, which is always below P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Counted-run completion interrupt |

## Verification
A sequencer stuck in the wrong state shows within one period. The count of active cycles over a window of whole periods is then off, and the count register reads nonzero while the channel is stopped. A bad working copy behind the hold bit shows as the old duty ratio lingering for more than one period after release, or as a new ratio appearing while the hold bit is set. An error in the run counter shows only when a counted run ends: too many or too few active cycles in total, the enable bit still reading 1, or the status bit staying clear.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int SCALE_W = 8;
    localparam int RUNS_W  = 8;

    localparam logic [ADDR_W-1:0] A_COUNT  = 5'h00;
    localparam logic [ADDR_W-1:0] A_PERIOD = 5'h04;
    localparam logic [ADDR_W-1:0] A_DUTY   = 5'h08;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h0C;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'h10;
    localparam logic [ADDR_W-1:0] A_IEN    = 5'h14;

    localparam int B_EN      = 0;
    localparam int B_MODE    = 1;
    localparam int B_ACT_HI  = 3;
    localparam int B_IDLE_HI = 4;
    localparam int B_CENTER  = 5;
    localparam int B_HOLD    = 6;
    localparam int B_SCALED  = 9;
    localparam int B_SCALE   = 16;
    localparam int B_RUNS    = 24;

    typedef enum logic [1:0] {
        MODE_COUNTED = 2'b00,
        MODE_FREE    = 2'b01,
        MODE_SAMPLE  = 2'b10,
        MODE_RSVD    = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] period;
        logic [DATA_W-1:0] duty;
        logic              act_hi;
        logic              idle_hi;
    } wave_cfg_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  cnt_val,
    input  logic               run_done,
    output wave_cfg_t          prog_cfg,
    output logic               en,
    output run_mode_e          mode,
    output logic               center,
    output logic               hold,
    output logic               scaled,
    output logic [SCALE_W-1:0] scale,
    output logic [RUNS_W-1:0]  runs_last,
    output logic               irq
);

    logic [DATA_W-1:0] period_q;
    logic [DATA_W-1:0] duty_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              sts_q;
    logic              ien_q;

    logic wr_stat_one;
    assign wr_stat_one = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            duty_q   <= '0;
            ctrl_q   <= '0;
            ien_q    <= 1'b0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    A_PERIOD: period_q <= bus_wdata;
                    A_DUTY:   duty_q   <= bus_wdata;
                    A_CTRL:   ctrl_q   <= bus_wdata;
                    A_IEN:    ien_q    <= bus_wdata[0];
                    default:  ;
                endcase
            end
            if (run_done) begin
                ctrl_q[B_EN] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (run_done) begin
            sts_q <= 1'b1;
        end else if (wr_stat_one) begin
            sts_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            A_COUNT:  bus_rdata = cnt_val;
            A_PERIOD: bus_rdata = period_q;
            A_DUTY:   bus_rdata = duty_q;
            A_CTRL:   bus_rdata = ctrl_q;
            A_STAT:   bus_rdata = {{(DATA_W-1){1'b0}}, sts_q};
            A_IEN:    bus_rdata = {{(DATA_W-1){1'b0}}, ien_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign prog_cfg.period  = period_q;
    assign prog_cfg.duty    = duty_q;
    assign prog_cfg.act_hi  = ctrl_q[B_ACT_HI];
    assign prog_cfg.idle_hi = ctrl_q[B_IDLE_HI];
    assign en        = ctrl_q[B_EN];
    assign mode      = run_mode_e'(ctrl_q[B_MODE +: 2]);
    assign center    = ctrl_q[B_CENTER];
    assign hold      = ctrl_q[B_HOLD];
    assign scaled    = ctrl_q[B_SCALED];
    assign scale     = ctrl_q[B_SCALE +: SCALE_W];
    assign runs_last = ctrl_q[B_RUNS +: RUNS_W];
    assign irq       = sts_q & ien_q;

    p_done_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !en);

    p_done_sets_sts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> sts_q);

    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_one && !run_done) |=> !sts_q);

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wave_cfg_t prog_cfg,
    input  logic      hold,
    input  logic      load_req,
    output wave_cfg_t act_cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cfg <= '0;
        end else if (load_req && !hold) begin
            act_cfg <= prog_cfg;
        end
    end

    p_hold_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(act_cfg));

    p_release_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !hold) |=> (act_cfg == $past(prog_cfg)));

endmodule

// File: rtl/pwm_clkdiv.sv
module pwm_clkdiv
    import pwm_pkg::*;
#(
    parameter int SW = SCALE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scaled,
    input  logic [SW-1:0] scale,
    input  logic          hold_cnt,
    output logic          tick
);

    localparam int DIV_W = SW + 2;
    localparam logic [DIV_W-1:0] ZERO_LIM = DIV_W'(1) << (SW + 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;
    logic             at_end;

    assign limit  = (scale == '0) ? ZERO_LIM : {1'b0, scale, 1'b0};
    assign at_end = (div_q == limit - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (hold_cnt || !scaled || at_end) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign tick = !scaled || (at_end && !hold_cnt);

    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && scaled) |=> (!tick || !scaled));

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CW = DATA_W,
    parameter int RW = RUNS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  run_mode_e     mode,
    input  logic          center,
    input  logic [RW-1:0] runs_last,
    input  logic          tick,
    input  wave_cfg_t     act_cfg,
    output logic [CW-1:0] cnt,
    output logic          pwm_out,
    output logic          load_req,
    output logic          run_done,
    output logic          idle
);

    seq_state_e    state, state_n;
    logic [CW-1:0] cnt_n;
    logic [RW-1:0] runs_q, runs_n;
    logic          go, counted, bnd, fin, at_top;
    logic [CW:0]   cnt_inc;

    assign go      = en && ((mode == MODE_COUNTED) || (mode == MODE_FREE));
    assign counted = (mode == MODE_COUNTED);
    assign cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign at_top  = (cnt_inc >= {1'b0, act_cfg.period});

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        runs_n  = runs_q;
        bnd     = 1'b0;
        fin     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_n  = '0;
                runs_n = '0;
                if (go) state_n = ST_UP;
            end
            ST_UP: begin
                if (!go) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else if (tick) begin
                    if (!at_top) begin
                        cnt_n = cnt + CW'(1);
                    end else if (center) begin
                        state_n = ST_DOWN;
                    end else begin
                        bnd   = 1'b1;
                        cnt_n = '0;
                    end
                end
            end
            ST_DOWN: begin
                if (!go) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else if (tick) begin
                    if (cnt != '0) begin
                        cnt_n = cnt - CW'(1);
                    end else begin
                        bnd     = 1'b1;
                        state_n = ST_UP;
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
        if (bnd) begin
            if (counted && (runs_q == runs_last)) begin
                fin     = 1'b1;
                state_n = ST_IDLE;
                cnt_n   = '0;
            end else begin
                runs_n = runs_q + RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            runs_q <= '0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            runs_q <= runs_n;
        end
    end

    always_comb begin
        idle     = (state == ST_IDLE);
        load_req = idle || bnd;
        run_done = fin;
        if (!idle && (cnt < act_cfg.duty)) begin
            pwm_out = act_cfg.act_hi;
        end else begin
            pwm_out = act_cfg.idle_hi;
        end
    end

    p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && (act_cfg.period != '0)) |-> (cnt < act_cfg.period));

    p_idle_count_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));

    p_done_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> (state == ST_IDLE));

    p_no_start_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !go) |=> (state == ST_IDLE));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out,
    output logic              irq
);

    wave_cfg_t          prog_cfg, act_cfg;
    logic               en, center, hold, scaled, tick;
    logic               load_req, run_done, idle;
    run_mode_e          mode;
    logic [SCALE_W-1:0] scale;
    logic [RUNS_W-1:0]  runs_last;
    logic [DATA_W-1:0]  cnt;

    pwm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt),
        .run_done  (run_done),
        .prog_cfg  (prog_cfg),
        .en        (en),
        .mode      (mode),
        .center    (center),
        .hold      (hold),
        .scaled    (scaled),
        .scale     (scale),
        .runs_last (runs_last),
        .irq       (irq)
    );

    pwm_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_cfg (prog_cfg),
        .hold     (hold),
        .load_req (load_req),
        .act_cfg  (act_cfg)
    );

    pwm_clkdiv #(.SW(SCALE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .scaled   (scaled),
        .scale    (scale),
        .hold_cnt (idle),
        .tick     (tick)
    );

    pwm_core #(.CW(DATA_W), .RW(RUNS_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mode      (mode),
        .center    (center),
        .runs_last (runs_last),
        .tick      (tick),
        .act_cfg   (act_cfg),
        .cnt       (cnt),
        .pwm_out   (pwm_out),
        .load_req  (load_req),
        .run_done  (run_done),
        .idle      (idle)
    );

endmodule

// File: tb/sim_pwm_chan.sv
`timescale 1ns/1ps
module sim_pwm_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        pwm_out;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    string  tag_q[$];
    longint exp_q[$];
    longint act_q[$];

    always #2.5 clk = ~clk;

    pwm_chan u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    // scoreboard monitor: pops expected items and compares with observations
    always @(negedge clk) begin
        while (exp_q.size() != 0 && act_q.size() != 0) begin
            string  t;
            longint e;
            longint a;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_run++;
            if (a != e) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected %0d", t, a, e);
            end
        end
    end

    task automatic push_check(input string t, input longint a, input longint e);
        tag_q.push_back(t);
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic highs(input int n, output longint h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        longint h;

        idle_cycles(4);
        rst_n = 1'b1;
        idle_cycles(2);

        // R1 reset state
        push_check("R1 out", pwm_out, 0);
        push_check("R1 irq", irq, 0);
        rd(5'h0C, d); push_check("R1 ctrl", d, 0);
        rd(5'h00, d); push_check("R1 count", d, 0);

        // R2 disabled holds idle level
        wr(5'h0C, 32'h10);
        idle_cycles(3);
        highs(20, h); push_check("R2 idle high", h, 20);
        rd(5'h00, d); push_check("R2 count", d, 0);

        // R3 edge-aligned free-running, P=10 D=3
        wr(5'h04, 10);
        wr(5'h08, 3);
        wr(5'h0C, 32'h0B);
        idle_cycles(20);
        highs(100, h); push_check("R3 active high", h, 30);
        rd(5'h00, d); push_check("R11 count below P", (d < 10) ? 1 : 0, 1);
        wr(5'h0C, 32'h13);
        idle_cycles(20);
        highs(100, h); push_check("R3 active low", h, 70);

        // R4 center-aligned
        wr(5'h0C, 32'h2B);
        idle_cycles(40);
        highs(200, h); push_check("R4 center", h, 60);

        // R5 scaled tick, N=2 -> /4
        wr(5'h0C, 32'h08);
        wr(5'h0C, 32'h0002_020B);
        idle_cycles(80);
        highs(400, h); push_check("R5 div4", h, 120);
        // R5 N=0 -> /512, prescale bits stored
        wr(5'h0C, 32'h08);
        wr(5'h04, 2);
        wr(5'h08, 1);
        wr(5'h0C, 32'h0000_320B);
        rd(5'h0C, d); push_check("R5 prescale readback", (d >> 12) & 3, 3);
        idle_cycles(100);
        highs(2048, h); push_check("R5 div512", h, 1024);

        // R6 hold freezes, R7 release applies at boundary
        wr(5'h0C, 32'h08);
        wr(5'h04, 10);
        wr(5'h08, 3);
        wr(5'h0C, 32'h0B);
        idle_cycles(20);
        wr(5'h0C, 32'h4B);
        wr(5'h04, 20);
        wr(5'h08, 15);
        wr(5'h0C, 32'h53);
        idle_cycles(30);
        highs(100, h); push_check("R6 held", h, 30);
        wr(5'h0C, 32'h13);
        idle_cycles(40);
        highs(200, h); push_check("R7 released", h, 50);

        // R8 counted run of 3 periods, R9 status and interrupt
        wr(5'h0C, 32'h08);
        wr(5'h14, 1);
        wr(5'h04, 10);
        wr(5'h08, 4);
        wr(5'h0C, 32'h0200_0009);
        highs(100, h); push_check("R8 three periods", h, 12);
        rd(5'h0C, d); push_check("R8 enable cleared", d & 1, 0);
        rd(5'h10, d); push_check("R9 status set", d & 1, 1);
        push_check("R9 irq high", irq, 1);
        wr(5'h14, 0);
        idle_cycles(1);
        push_check("R9 irq gated", irq, 0);
        rd(5'h10, d); push_check("R9 status sticky", d & 1, 1);
        wr(5'h10, 1);
        rd(5'h10, d); push_check("R9 status cleared", d & 1, 0);

        // R8 single period and 256 periods
        wr(5'h0C, 32'h09);
        highs(60, h); push_check("R8 one period", h, 4);
        wr(5'h10, 1);
        wr(5'h08, 1);
        wr(5'h0C, 32'hFF00_0009);
        highs(2700, h); push_check("R8 256 periods", h, 256);
        rd(5'h0C, d); push_check("R8 enable cleared 256", d & 1, 0);

        // R10 unsupported modes stay idle
        wr(5'h0C, 32'h15);
        idle_cycles(5);
        highs(50, h); push_check("R10 mode10 idle", h, 50);
        rd(5'h00, d); push_check("R10 mode10 count", d, 0);
        wr(5'h0C, 32'h17);
        idle_cycles(5);
        highs(50, h); push_check("R10 mode11 idle", h, 50);

        idle_cycles(3);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule